// File: doc/BRIEF.md
# Timer Bank Register Controller

This block is the register front end for a bank of eight timer channels. It holds one packed control word with a four-bit field per channel. It routes register reads and writes to the channels' own registers, and it keeps a sticky word of per-channel interrupt status. It drives the per-channel enable, clock-select, overflow-interrupt-enable and pulse-enable signals straight to the counting logic. That counting logic is outside this block.

Requests arrive on a valid/ready channel carrying a write flag, a byte address and 32 bits of write data. Every access is a 32-bit, aligned, little-endian word. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in two cases: while a control update is being sequenced, and while an earlier read response is waiting and `rsp_ready` is low. A read returns exactly one response on the `rsp_*` channel. That response stays valid and stable until it is accepted. A write gives no response.

When the control word changes, each channel is updated in order. A channel being switched off loses its enable first and gets its new configuration one cycle later. A channel being switched on gets its configuration first and its enable one cycle later. A separate clear-by-mask register can drop control bits. It only works after an unlock key has been written to a lock register.

Top module: `tmr_bank_regs`

## Requirements
- R1: After reset the control word and the status word are zero, the clear register is locked, `rsp_valid` is low and every channel output is low.
- R2: The control word is at offset 0x30, and channel c uses bits [4c+3:4c]: bit 4c is enable, 4c+1 is external clock select, 4c+2 is overflow interrupt enable and 4c+3 is pulse enable. These bits drive the matching `chan_*` outputs, and a read of 0x30 returns the stored word.
- R3: Channels 0–3 cannot pulse. Their pulse bits are never stored and always read back as 0. A control write that tries to set one of them raises `pulse_reject` for exactly one cycle, starting the cycle after the write is accepted. Channels 4–7 store their pulse bit.
- R4: In the cycle after a control update is accepted, a channel that turns on shows its new configuration with enable still 0. A channel that turns off shows enable 0 with its old configuration. One cycle later the full new word is in place. `req_ready` is low during the cycle in between.
- R5: Offsets 0x00, 0x10 and 0x20 select channels 0–2. Offsets 0x40 through 0x80, in steps of 0x10, select channels 3–7. Address bits [3:2] select the channel register (0 count, 1 reload, 2 first match, 3 second match). An accepted write raises `chan_wr_valid` in the same cycle, and a read returns `chan_rd_data`.
- R6: A high `chan_event[c]` sets status bit c on the next edge. Offset 0x34 reads the status word. If an event and a clear of the same bit fall on the same edge, the bit stays set.
- R7: Writing 1 to a bit of offset 0x34 clears that status bit. Writing 0 leaves it unchanged.
- R8: A write to 0x38 with data bits [8:1] equal to 0xAE unlocks the clear register, and 0xEA locks it again. Any other value changes nothing. A read of 0x38 returns 1 in bit 0 while unlocked.
- R9: While unlocked, a write to 0x3C clears the control bits set in the data, using the R4 ordering. While locked, such a write leaves the control word unchanged.
- R10: A misaligned address, or any offset not listed above, reads as zero. A write to such an address changes nothing and raises no channel write strobe.
- R11: A read response holds `rsp_valid` and `rsp_rdata` stable until `rsp_ready` is high. While it waits, `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data accepted |
| rsp_rdata | output | 32 | Read data |
| chan_sel | output | 3 | Channel selected by the request address |
| chan_reg | output | 2 | Channel register selected by the request address |
| chan_wr_valid | output | 1 | Write strobe for the selected channel register |
| chan_wr_data | output | 32 | Write data for the channel register |
| chan_rd_data | input | 32 | Read data from the selected channel register |
| chan_event | input | 8 | Per-channel interrupt events |
| chan_enable | output | 8 | Per-channel enable |
| chan_ext_clk | output | 8 | Per-channel external clock select |
| chan_ovf_ie | output | 8 | Per-channel overflow interrupt enable |
| chan_pulse_en | output | 8 | Per-channel pulse enable |
| pulse_reject | output | 1 | One-cycle flag: pulse requested on a channel that cannot pulse |

## Verification
The hardest things to reach from the ports are the one-cycle intermediate control state and the collision between an event and a status clear. The stimulus switches a channel on and off with every configuration bit changing at once. It then samples the outputs in the first cycle after acceptance and again in the next, so both the ordered half-step and the final word are seen. For the collision, the bench raises the event input in exactly the cycle whose closing edge accepts the clear, and drops it right after that edge. The set-wins rule is therefore the only way the bit can survive.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  localparam int unsigned TBR_NCH   = 8;
  localparam int unsigned TBR_CHW   = $clog2(TBR_NCH);
  localparam int unsigned TBR_NIB   = 4;
  localparam int unsigned TBR_AW    = 8;
  localparam int unsigned TBR_DW    = 32;
  localparam int unsigned TBR_REGW  = 2;
  // bit positions inside a channel's control field
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_EXT   = 1;
  localparam int unsigned BIT_OVF   = 2;
  localparam int unsigned BIT_PULSE = 3;

  typedef enum logic [2:0] {
    K_NONE,
    K_CHAN,
    K_CTRL,
    K_STAT,
    K_LOCK,
    K_CLR
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e             kind;
    logic [TBR_CHW-1:0]    ch;
    logic [TBR_REGW-1:0]   idx;
  } dec_t;
endpackage

// File: rtl/tbr_decode.sv
module tbr_decode
  import tbr_pkg::*;
#(
  parameter int unsigned LOW_SLOTS = 3
) (
  input  logic [TBR_AW-1:0] addr,
  output dec_t              dec
);
  localparam int unsigned HIGH_FIRST = LOW_SLOTS + 1;
  localparam int unsigned HIGH_END   = HIGH_FIRST + (TBR_NCH - LOW_SLOTS);

  logic [3:0] slot;
  logic       aligned;
  logic [3:0] hi_ch;

  assign slot    = addr[7:4];
  assign aligned = (addr[1:0] == 2'b00);
  assign hi_ch   = slot - 4'd1;

  always_comb begin
    dec.kind = K_NONE;
    dec.ch   = '0;
    dec.idx  = addr[3:2];
    if (aligned) begin
      if (32'(slot) < LOW_SLOTS) begin
        dec.kind = K_CHAN;
        dec.ch   = slot[TBR_CHW-1:0];
      end else if (32'(slot) == LOW_SLOTS) begin
        unique case (addr[3:2])
          2'd0: dec.kind = K_CTRL;
          2'd1: dec.kind = K_STAT;
          2'd2: dec.kind = K_LOCK;
          default: dec.kind = K_CLR;
        endcase
      end else if (32'(slot) >= HIGH_FIRST && 32'(slot) < HIGH_END) begin
        dec.kind = K_CHAN;
        dec.ch   = hi_ch[TBR_CHW-1:0];
      end
    end
  end
endmodule

// File: rtl/tbr_ctrl_seq.sv
module tbr_ctrl_seq
  import tbr_pkg::*;
#(
  parameter int unsigned NCH         = TBR_NCH,
  parameter int unsigned PULSE_FIRST = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_valid,
  input  logic [NCH*TBR_NIB-1:0] upd_word,
  output logic [NCH*TBR_NIB-1:0] ctrl_q,
  output logic               busy
);
  localparam int unsigned CW = NCH * TBR_NIB;

  logic [CW-1:0] allow;
  logic [CW-1:0] new_w;
  logic [CW-1:0] ph_a;
  logic [CW-1:0] tgt_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int unsigned B = i * TBR_NIB;
    logic was_en;
    logic want_en;
    assign allow[B+BIT_PULSE]    = (i >= PULSE_FIRST);
    assign allow[B+BIT_OVF:B]    = '1;
    assign was_en                = ctrl_q[B+BIT_EN];
    assign want_en               = new_w[B+BIT_EN];
    // first half-step: enable only survives if kept; config waits when turning off
    assign ph_a[B+BIT_EN]        = was_en & want_en;
    assign ph_a[B+BIT_PULSE:B+1] = (was_en & ~want_en) ? ctrl_q[B+BIT_PULSE:B+1]
                                                      : new_w[B+BIT_PULSE:B+1];

    assert_enable_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q[B+BIT_EN]) |-> $stable(ctrl_q[B+BIT_PULSE:B+1]));
    assert_disable_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_q[B+BIT_EN]) |-> $stable(ctrl_q[B+BIT_PULSE:B+1]));
  end

  assign new_w = upd_word & allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tgt_q  <= '0;
      busy   <= 1'b0;
    end else if (upd_valid) begin
      ctrl_q <= ph_a;
      tgt_q  <= new_w;
      busy   <= 1'b1;
    end else if (busy) begin
      ctrl_q <= tgt_q;
      busy   <= 1'b0;
    end
  end

  assert_single_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_no_update_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !upd_valid);
endmodule

// File: rtl/tbr_irq_status.sv
module tbr_irq_status
  import tbr_pkg::*;
#(
  parameter int unsigned NCH = TBR_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev,
  input  logic           clr_valid,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] sts
);
  logic [NCH-1:0] clr_eff;

  assign clr_eff = clr_valid ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr_eff) | ev;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> sts[i]);
    assert_only_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts[i]) |-> $past(clr_valid && clr_mask[i]));
  end
endmodule

// File: rtl/tmr_bank_regs.sv
module tmr_bank_regs
  import tbr_pkg::*;
#(
  parameter int unsigned PULSE_FIRST = 4,
  parameter int unsigned LOW_SLOTS   = 3,
  parameter logic [7:0]  UNLOCK_KEY  = 8'hAE,
  parameter logic [7:0]  LOCK_KEY    = 8'hEA
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [TBR_AW-1:0]   req_addr,
  input  logic [TBR_DW-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [TBR_DW-1:0]   rsp_rdata,
  output logic [TBR_CHW-1:0]  chan_sel,
  output logic [TBR_REGW-1:0] chan_reg,
  output logic                chan_wr_valid,
  output logic [TBR_DW-1:0]   chan_wr_data,
  input  logic [TBR_DW-1:0]   chan_rd_data,
  input  logic [TBR_NCH-1:0]  chan_event,
  output logic [TBR_NCH-1:0]  chan_enable,
  output logic [TBR_NCH-1:0]  chan_ext_clk,
  output logic [TBR_NCH-1:0]  chan_ovf_ie,
  output logic [TBR_NCH-1:0]  chan_pulse_en,
  output logic                pulse_reject
);
  localparam int unsigned NCH = TBR_NCH;
  localparam int unsigned CW  = NCH * TBR_NIB;

  dec_t          dec;
  logic          acc;
  logic          busy;
  logic          unlocked;
  logic [CW-1:0] ctrl_w;
  logic          upd_valid;
  logic [CW-1:0] upd_word;
  logic          sts_clr;
  logic [NCH-1:0] sts;
  logic [CW-1:0] low_pulse_mask;
  logic [TBR_DW-1:0] rd_val;
  logic [7:0]    key;

  tbr_decode #(.LOW_SLOTS(LOW_SLOTS)) u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  assign req_ready = !busy && (!rsp_valid || rsp_ready);
  assign acc       = req_valid && req_ready;

  // channel register routing
  assign chan_sel      = dec.ch;
  assign chan_reg      = dec.idx;
  assign chan_wr_data  = req_wdata;
  assign chan_wr_valid = acc && req_write && (dec.kind == K_CHAN);

  // control updates: direct writes and unlocked masked clears
  assign upd_valid = acc && req_write &&
                     ((dec.kind == K_CTRL) || ((dec.kind == K_CLR) && unlocked));
  assign upd_word  = (dec.kind == K_CTRL) ? req_wdata[CW-1:0]
                                          : (ctrl_w & ~req_wdata[CW-1:0]);

  tbr_ctrl_seq #(.NCH(NCH), .PULSE_FIRST(PULSE_FIRST)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_word  (upd_word),
    .ctrl_q    (ctrl_w),
    .busy      (busy)
  );

  assign sts_clr = acc && req_write && (dec.kind == K_STAT);

  tbr_irq_status #(.NCH(NCH)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (chan_event),
    .clr_valid (sts_clr),
    .clr_mask  (req_wdata[NCH-1:0]),
    .sts       (sts)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_out
    localparam int unsigned B = i * TBR_NIB;
    assign chan_enable[i]   = ctrl_w[B+BIT_EN];
    assign chan_ext_clk[i]  = ctrl_w[B+BIT_EXT];
    assign chan_ovf_ie[i]   = ctrl_w[B+BIT_OVF];
    assign chan_pulse_en[i] = ctrl_w[B+BIT_PULSE];
    assign low_pulse_mask[B+BIT_PULSE] = (i < PULSE_FIRST);
    assign low_pulse_mask[B+BIT_OVF:B] = '0;
    if (i < PULSE_FIRST) begin : g_nopulse
      assert_no_pulse_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_pulse_en[i]);
    end
  end

  // lock register and pulse rejection flag
  assign key = req_wdata[8:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked     <= 1'b0;
      pulse_reject <= 1'b0;
    end else begin
      if (acc && req_write && (dec.kind == K_LOCK)) begin
        if (key == UNLOCK_KEY)    unlocked <= 1'b1;
        else if (key == LOCK_KEY) unlocked <= 1'b0;
      end
      pulse_reject <= acc && req_write && (dec.kind == K_CTRL) &&
                      |(req_wdata[CW-1:0] & low_pulse_mask);
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    unique case (dec.kind)
      K_CHAN: rd_val = chan_rd_data;
      K_CTRL: rd_val[CW-1:0] = ctrl_w;
      K_STAT: rd_val[NCH-1:0] = sts;
      K_LOCK: rd_val[0] = unlocked;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_stall_while_waiting_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  assert_locked_clear_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && (dec.kind == K_CLR) && !unlocked) |=> $stable(ctrl_w));
  assert_no_strobe_off_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.kind == K_NONE) |-> !chan_wr_valid);
endmodule

// File: tb/tmr_bank_regs_bench.sv
module tmr_bank_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [2:0]  chan_sel;
  logic [1:0]  chan_reg;
  logic        chan_wr_valid;
  logic [31:0] chan_wr_data;
  logic [31:0] chan_rd_data;
  logic [7:0]  chan_event = '0;
  logic [7:0]  chan_enable, chan_ext_clk, chan_ovf_ie, chan_pulse_en;
  logic        pulse_reject;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  // channel model: read data encodes the selected channel and register
  assign chan_rd_data = {16'hCA00, 5'b0, chan_sel, 6'b0, chan_reg};

  tmr_bank_regs u_tmr_bank_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .chan_sel(chan_sel), .chan_reg(chan_reg), .chan_wr_valid(chan_wr_valid),
    .chan_wr_data(chan_wr_data), .chan_rd_data(chan_rd_data),
    .chan_event(chan_event), .chan_enable(chan_enable), .chan_ext_clk(chan_ext_clk),
    .chan_ovf_ie(chan_ovf_ie), .chan_pulse_en(chan_pulse_en), .pulse_reject(pulse_reject)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #0;
    while (!req_ready) begin
      @(negedge clk);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    do_req(1'b0, a, 32'h0);
  endtask

  task automatic probe_wr(input logic [7:0] a, input bit exp_v, input logic [2:0] ch,
                          input logic [1:0] rg, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = 32'h5A5A_0000 | 32'(a);
    #1;
    chk(chan_wr_valid == exp_v, tag, 32'(chan_wr_valid), 32'(exp_v));
    if (exp_v) begin
      chk(chan_sel == ch && chan_reg == rg, tag, {27'b0, chan_sel, chan_reg}, {27'b0, ch, rg});
      chk(chan_wr_data == req_wdata, tag, chan_wr_data, req_wdata);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected response", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(chan_enable == 0 && chan_ext_clk == 0 && chan_ovf_ie == 0 && chan_pulse_en == 0,
        "R1 channel outputs", {chan_enable, chan_ext_clk, chan_ovf_ie, chan_pulse_en}, 32'h0);
    chk(!rsp_valid && req_ready, "R1 handshake idle", {30'b0, rsp_valid, req_ready}, 32'h1);
    rd(8'h30, 32'h0, "R1 control word");
    rd(8'h34, 32'h0, "R1 status word");
    rd(8'h38, 32'h0, "R1 locked");

    // R5 routing of reads and write strobes
    rd(8'h00, 32'hCA00_0000, "R5 ch0 count");
    rd(8'h14, 32'hCA00_0101, "R5 ch1 reload");
    rd(8'h28, 32'hCA00_0202, "R5 ch2 match1");
    rd(8'h48, 32'hCA00_0302, "R5 ch3 match1");
    rd(8'h7C, 32'hCA00_0603, "R5 ch6 match2");
    rd(8'h8C, 32'hCA00_0703, "R5 ch7 match2");
    probe_wr(8'h24, 1'b1, 3'd2, 2'd1, "R5 write ch2 reload");
    probe_wr(8'h58, 1'b1, 3'd4, 2'd2, "R5 write ch4 match1");
    probe_wr(8'h40, 1'b1, 3'd3, 2'd0, "R5 write ch3 count");

    // R4 + R2: enable ch5 with all config bits
    do_req(1'b1, 8'h30, 32'h00F0_0000);
    @(negedge clk);
    chk(!chan_enable[5] && chan_ext_clk[5] && chan_ovf_ie[5] && chan_pulse_en[5],
        "R4 enable after config (first step)",
        {28'b0, chan_pulse_en[5], chan_ovf_ie[5], chan_ext_clk[5], chan_enable[5]}, 32'hE);
    chk(!req_ready, "R4 stall cycle", 32'(req_ready), 32'h0);
    @(negedge clk);
    chk(chan_enable[5] && req_ready, "R4 enable lands", {30'b0, chan_enable[5], req_ready}, 32'h3);
    rd(8'h30, 32'h00F0_0000, "R2 control readback");
    // R4 disable before config
    do_req(1'b1, 8'h30, 32'h0);
    @(negedge clk);
    chk(!chan_enable[5] && chan_ext_clk[5] && chan_pulse_en[5], "R4 disable first",
        {28'b0, chan_pulse_en[5], chan_ovf_ie[5], chan_ext_clk[5], chan_enable[5]}, 32'hE);
    @(negedge clk);
    chk(!chan_ext_clk[5] && !chan_ovf_ie[5] && !chan_pulse_en[5], "R4 config after disable",
        {28'b0, chan_pulse_en[5], chan_ovf_ie[5], chan_ext_clk[5], chan_enable[5]}, 32'h0);

    // R3 pulse on non-capable channels
    do_req(1'b1, 8'h30, 32'h0000_0098);
    @(negedge clk);
    chk(pulse_reject, "R3 reject flag raised", 32'(pulse_reject), 32'h1);
    @(negedge clk);
    chk(!pulse_reject, "R3 reject flag one cycle", 32'(pulse_reject), 32'h0);
    rd(8'h30, 32'h0000_0010, "R3 low pulse bits dropped");
    do_req(1'b1, 8'h30, 32'h8000_0000);
    @(negedge clk);
    chk(!pulse_reject, "R3 no reject on ch7", 32'(pulse_reject), 32'h0);
    rd(8'h30, 32'h8000_0000, "R3 ch7 pulse kept");

    // R6 / R7 status
    @(negedge clk); chan_event = 8'h44;
    @(negedge clk); chan_event = 8'h00;
    rd(8'h34, 32'h0000_0044, "R6 events latched");
    do_req(1'b1, 8'h34, 32'h0000_0004);
    rd(8'h34, 32'h0000_0040, "R7 write one clears");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h34; req_wdata = 32'h40;
    chan_event = 8'h40;
    @(posedge clk);
    #1 req_valid = 1'b0; chan_event = 8'h00;
    rd(8'h34, 32'h0000_0040, "R6 set wins over clear");
    do_req(1'b1, 8'h34, 32'h0000_0040);
    rd(8'h34, 32'h0000_0000, "R7 cleared");

    // R8 / R9 lock and masked clear
    do_req(1'b1, 8'h30, 32'h00F3_0001);
    do_req(1'b1, 8'h3C, 32'hFFFF_FFFF);
    rd(8'h30, 32'h00F3_0001, "R9 locked clear ignored");
    do_req(1'b1, 8'h38, 32'h0000_015A);
    rd(8'h38, 32'h0, "R8 wrong key ignored");
    do_req(1'b1, 8'h38, 32'h0000_015C);
    rd(8'h38, 32'h1, "R8 unlocked");
    do_req(1'b1, 8'h3C, 32'h0002_0001);
    rd(8'h30, 32'h00F1_0000, "R9 masked clear");
    do_req(1'b1, 8'h3C, 32'h00F0_0000);
    @(negedge clk);
    chk(!chan_enable[5] && chan_ext_clk[5], "R9 clear disables first",
        {30'b0, chan_ext_clk[5], chan_enable[5]}, 32'h2);
    @(negedge clk);
    chk(!chan_ext_clk[5], "R9 clear config after", 32'(chan_ext_clk[5]), 32'h0);
    rd(8'h30, 32'h0001_0000, "R9 after ordered clear");
    do_req(1'b1, 8'h38, 32'h0000_01D4);
    rd(8'h38, 32'h0, "R8 relocked");
    do_req(1'b1, 8'h3C, 32'h0001_0000);
    rd(8'h30, 32'h0001_0000, "R9 relocked clear ignored");

    // R10 undecoded
    rd(8'h90, 32'h0, "R10 read past map");
    rd(8'hFC, 32'h0, "R10 read top");
    rd(8'h32, 32'h0, "R10 misaligned read");
    do_req(1'b1, 8'h31, 32'hFFFF_FFFF);
    rd(8'h30, 32'h0001_0000, "R10 misaligned write ignored");
    probe_wr(8'hA0, 1'b0, 3'd0, 2'd0, "R10 no strobe off map");
    probe_wr(8'h31, 1'b0, 3'd0, 2'd0, "R10 no strobe misaligned");

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    exp_q.push_back(32'h0001_0000);
    tag_q.push_back("R11 held response");
    do_req(1'b0, 8'h30, 32'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_rdata == 32'h0001_0000, "R11 hold while stalled",
          rsp_rdata, 32'h0001_0000);
    end
    rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule